// File: doc/BRIEF.md
# Interleaved I/Q Parallel Output Port

This block drains baseband samples from up to four receive channels onto a 16-bit parallel bus that runs on the port clock. Each channel delivers an I word and a Q word together over a valid/ready input. The port holds them in a one-deep slot per channel and serves the slots in a round-robin order over the channels that a mask enables. An external consumer paces the bus with an acknowledge input. While the port has a word to offer it raises its request output, and a word moves on each port-clock rising edge where request and acknowledge are both high. Each sample goes out as two beats: first the I word with the I/Q flag high, then the Q word with the flag low. A 2-bit channel tag goes with both beats.

Three plain control pins set the port up: an enable, a mode select and the per-channel mask. With the mode select low, the bus carries the byte-wide link data on its low eight bits instead, and the parallel handshake stays idle.

Back-pressure rules: on the sample inputs, `smp_ready` only tells the producer that the slot is empty. A producer that pushes into a full slot replaces the unsent sample, and this sets that channel's sticky overflow flag. On the output side, the consumer holds off the bus by keeping `pp_ack` low, and the bus keeps the last word it presented.

Top module: `iq_par_port`

## Requirements
- R1: After reset, `pp_data`, `pp_iq`, `pp_chan`, `pp_req` and `ovf_flag` are all zero, and every `smp_ready` bit is 1.
- R2: In channel mode (`port_en`=1, `port_chmode`=1), `pp_req` is high exactly when a Q beat is still owed, or when some channel whose `chan_mask` bit is 1 holds a pending sample.
- R3: On a rising edge with `pp_req`=1, `pp_ack`=1 and no Q beat owed, the port takes the chosen sample. From the next cycle on, `pp_data` shows its I word, `pp_iq` is 1 and `pp_chan` shows the channel index. Index 0 is channel 1 and index 3 is channel 4. Taking the sample frees its slot.
- R4: On the next rising edge with `pp_req`=1 and `pp_ack`=1, `pp_data` changes to the Q word of the same sample, `pp_iq` goes to 0 and `pp_chan` stays the same.
- R5: While a Q beat is owed and `pp_ack` is low, `pp_data` keeps the I word and `pp_iq` stays 1.
- R6: Among the channels that are pending and enabled by the mask, the port serves the first one found in ascending index order, starting just after the channel it served last and wrapping from index 3 back to index 0. After reset, or after the port leaves channel mode, the search starts at index 0. A channel whose mask bit is 0 is skipped, and its sample stays pending.
- R7: A sample that arrives while the channel's slot is still pending replaces the old sample, which is never sent. It also sets bit n of `ovf_flag` for that channel, and the bit stays set until reset.
- R8: While `port_en`=0, `pp_data`, `pp_iq`, `pp_chan` and `pp_req` are 0 in the same cycle. Every pending sample is discarded, so after re-enabling `pp_req` stays 0 until new samples arrive.
- R9: With `port_en`=1 and `port_chmode`=0 (link mode), `pp_data` is `{8'h00, link_byte}` in the same cycle and `pp_req` is 0.
- R10: `smp_ready[n]` is 1 exactly when channel n's slot holds no pending sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable |
| port_chmode | input | 1 | 1 selects the parallel I/Q mode, 0 selects link byte mode |
| chan_mask | input | 4 | Bit n enables the output of channel index n |
| smp_valid | input | 4 | Per-channel sample strobe |
| smp_ready | output | 4 | Per-channel flag, 1 when the slot is empty |
| smp_i | input | 64 | I words; channel n uses bits [16n+15:16n] |
| smp_q | input | 64 | Q words; same packing as the I words |
| link_byte | input | 8 | Link data that is put on the low byte in link mode |
| pp_ack | input | 1 | Consumer acknowledge |
| pp_req | output | 1 | Port has a word to offer |
| pp_data | output | 16 | Parallel data bus |
| pp_iq | output | 1 | 1 for the I beat, 0 for the Q beat |
| pp_chan | output | 2 | Index of the channel on the bus |
| ovf_flag | output | 4 | Sticky per-channel overwrite flags |

## Verification
The properties assume that the configuration pins change only at clock edges, and that the consumer's acknowledge is a synchronous level with no further meaning. Nothing is assumed about when samples arrive. The stimulus loads samples while acknowledge is low, so every slot and the mask are settled before draining starts, which keeps the expected order exact. Acknowledge is then held high for back-to-back beats, or pulsed for one edge to open a Q-beat stall. Mode and mask change only while the bus is idle or on purpose to test disabling, and the bench restarts its own round-robin pointer each time the port leaves channel mode.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;
  localparam int unsigned IQ_DATA_W = 16;
  localparam int unsigned IQ_LINK_W = 8;
  localparam int unsigned IQ_NUM_CH = 4;

  // one beat as seen on the parallel bus
  typedef struct packed {
    logic [IQ_DATA_W-1:0] data;
    logic                 iq;
  } iq_beat_t;
endpackage

// File: rtl/iq_chan_slot.sv
module iq_chan_slot #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic              take,
  output logic              pend,
  output logic [DATA_W-1:0] hold_i,
  output logic [DATA_W-1:0] hold_q,
  output logic              ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      hold_i <= '0;
      hold_q <= '0;
      ovf    <= 1'b0;
    end else if (flush) begin
      pend <= 1'b0;
    end else if (in_vld) begin
      hold_i <= in_i;
      hold_q <= in_q;
      pend   <= 1'b1;
      // old sample lost only if it was not leaving on this edge
      if (pend && !take) ovf <= 1'b1;
    end else if (take) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_rr_pick.sv
module iq_rr_pick #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] cand,
  input  logic [IDX_W-1:0]  last,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);
  // walk from farthest to nearest so the nearest candidate wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = NUM_CH; k >= 1; k--) begin
      int unsigned j;
      j = (int'(last) + k) % NUM_CH;
      if (cand[j]) begin
        any = 1'b1;
        idx = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/iq_tx_seq.sv
module iq_tx_seq
  import iq_port_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              ack,
  input  logic              gnt_any,
  input  logic [IDX_W-1:0]  gnt_idx,
  input  logic [DATA_W-1:0] gnt_i,
  input  logic [DATA_W-1:0] gnt_q,
  output logic              req,
  output logic              take,
  output logic [IDX_W-1:0]  last,
  output logic [DATA_W-1:0] bus_data,
  output logic              q_owed,
  output logic [IDX_W-1:0]  bus_ch
);
  logic [DATA_W-1:0] q_word;
  logic              fire;

  assign req  = active && (q_owed || gnt_any);
  assign fire = req && ack;
  assign take = fire && !q_owed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_data <= '0;
      q_word   <= '0;
      q_owed   <= 1'b0;
      bus_ch   <= '0;
      last     <= IDX_W'(NUM_CH - 1);
    end else if (!active) begin
      bus_data <= '0;
      q_owed   <= 1'b0;
      bus_ch   <= '0;
      last     <= IDX_W'(NUM_CH - 1);
    end else if (fire) begin
      if (q_owed) begin
        bus_data <= q_word;
        q_owed   <= 1'b0;
      end else begin
        bus_data <= gnt_i;
        q_word   <= gnt_q;
        q_owed   <= 1'b1;
        bus_ch   <= gnt_idx;
        last     <= gnt_idx;
      end
    end
  end
endmodule

// File: rtl/iq_par_port.sv
module iq_par_port
  import iq_port_pkg::*;
#(
  parameter int unsigned DATA_W = IQ_DATA_W,
  parameter int unsigned LINK_W = IQ_LINK_W,
  parameter int unsigned NUM_CH = IQ_NUM_CH,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     port_en,
  input  logic                     port_chmode,
  input  logic [NUM_CH-1:0]        chan_mask,
  input  logic [NUM_CH-1:0]        smp_valid,
  output logic [NUM_CH-1:0]        smp_ready,
  input  logic [NUM_CH*DATA_W-1:0] smp_i,
  input  logic [NUM_CH*DATA_W-1:0] smp_q,
  input  logic [LINK_W-1:0]        link_byte,
  input  logic                     pp_ack,
  output logic                     pp_req,
  output logic [DATA_W-1:0]        pp_data,
  output logic                     pp_iq,
  output logic [IDX_W-1:0]         pp_chan,
  output logic [NUM_CH-1:0]        ovf_flag
);
  logic              chan_on;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] take_vec;
  logic [DATA_W-1:0] hold_i [NUM_CH];
  logic [DATA_W-1:0] hold_q [NUM_CH];
  logic              gnt_any, take, q_owed, req_int;
  logic [IDX_W-1:0]  gnt_idx, last, bus_ch;
  logic [DATA_W-1:0] bus_data;

  assign chan_on = port_en && port_chmode;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    assign take_vec[c] = take && (gnt_idx == IDX_W'(c));
    iq_chan_slot #(.DATA_W(DATA_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (!chan_on),
      .in_vld (smp_valid[c]),
      .in_i   (smp_i[c*DATA_W +: DATA_W]),
      .in_q   (smp_q[c*DATA_W +: DATA_W]),
      .take   (take_vec[c]),
      .pend   (pend[c]),
      .hold_i (hold_i[c]),
      .hold_q (hold_q[c]),
      .ovf    (ovf_flag[c])
    );
  end

  assign smp_ready = ~pend;

  iq_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
    .cand (pend & chan_mask),
    .last (last),
    .any  (gnt_any),
    .idx  (gnt_idx)
  );

  iq_tx_seq #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (chan_on),
    .ack      (pp_ack),
    .gnt_any  (gnt_any),
    .gnt_idx  (gnt_idx),
    .gnt_i    (hold_i[gnt_idx]),
    .gnt_q    (hold_q[gnt_idx]),
    .req      (req_int),
    .take     (take),
    .last     (last),
    .bus_data (bus_data),
    .q_owed   (q_owed),
    .bus_ch   (bus_ch)
  );

  // pin sharing: link byte on the low lanes outside channel mode
  always_comb begin
    pp_data = '0;
    pp_iq   = 1'b0;
    pp_chan = '0;
    pp_req  = 1'b0;
    if (chan_on) begin
      pp_data = bus_data;
      pp_iq   = q_owed;
      pp_chan = bus_ch;
      pp_req  = req_int;
    end else if (port_en) begin
      pp_data[LINK_W-1:0] = link_byte;
    end
  end
endmodule

// File: rtl/iq_par_port_chk.sv
module iq_par_port_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LINK_W = 8,
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_en,
  input logic              port_chmode,
  input logic [LINK_W-1:0] link_byte,
  input logic              pp_ack,
  input logic              pp_req,
  input logic [DATA_W-1:0] pp_data,
  input logic              pp_iq,
  input logic [IDX_W-1:0]  pp_chan,
  input logic [NUM_CH-1:0] ovf_flag
);
  logic chan_on;
  assign chan_on = port_en && port_chmode;

  // R2
  q_owed_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && pp_iq) |-> pp_req);

  // R3
  i_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && pp_req && pp_ack && !pp_iq) |=> (pp_iq || !chan_on));

  // R4
  q_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && pp_req && pp_ack && pp_iq) |=> ((!pp_iq && $stable(pp_chan)) || !chan_on));

  // R5
  q_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && pp_iq && !pp_ack) |=> ((pp_iq && $stable(pp_data)) || !chan_on));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ovf_flag) & ~ovf_flag) == '0));

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (pp_data == '0 && !pp_iq && !pp_req && pp_chan == '0));

  // R9
  link_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !port_chmode) |-> (pp_data == DATA_W'(link_byte) && !pp_req));
endmodule

bind iq_par_port iq_par_port_chk #(
  .DATA_W(DATA_W), .LINK_W(LINK_W), .NUM_CH(NUM_CH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .port_chmode(port_chmode),
  .link_byte(link_byte), .pp_ack(pp_ack), .pp_req(pp_req), .pp_data(pp_data),
  .pp_iq(pp_iq), .pp_chan(pp_chan), .ovf_flag(ovf_flag)
);

// File: tb/test_iq_par_port.sv
`timescale 1ns/1ps
module test_iq_par_port;
  localparam int NCH = 4;
  localparam int DW  = 16;

  typedef struct packed {
    logic [DW-1:0] d;
    logic          iq;
    logic [1:0]    ch;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b0, port_chmode = 1'b0;
  logic [NCH-1:0] chan_mask = '0, smp_valid = '0, smp_ready, ovf_flag;
  logic [NCH*DW-1:0] smp_i = '0, smp_q = '0;
  logic [7:0] link_byte = '0;
  logic pp_ack = 1'b0, pp_req, pp_iq;
  logic [DW-1:0] pp_data;
  logic [1:0] pp_chan;

  int vecs = 0, bad = 0;
  bit done = 0;
  item_t exp_q[$];

  // bench model of slots and pointer
  bit m_pend[NCH];
  logic [DW-1:0] m_i[NCH], m_q[NCH];
  int m_last = NCH - 1;

  always #4 clk = ~clk;

  iq_par_port i_iq_par_port (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .port_chmode(port_chmode),
    .chan_mask(chan_mask), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_i(smp_i), .smp_q(smp_q), .link_byte(link_byte), .pp_ack(pp_ack),
    .pp_req(pp_req), .pp_data(pp_data), .pp_iq(pp_iq), .pp_chan(pp_chan),
    .ovf_flag(ovf_flag)
  );

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: one beat expected after each edge that saw req && ack
  bit hs_prev = 0;
  always @(negedge clk) begin
    if (hs_prev) begin
      if (exp_q.size() == 0) begin
        vecs++; bad++;
        $display("FAIL R3 actual=%h expected=<none>", {pp_data, pp_iq, pp_chan});
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk({pp_data, pp_iq, pp_chan} == e, e.iq ? "R3/R6 I beat" : "R4 Q beat",
            32'({pp_data, pp_iq, pp_chan}), 32'(e));
      end
    end
    hs_prev = rst_n && port_en && port_chmode && pp_req && pp_ack;
  end

  task automatic load(input int c, input logic [DW-1:0] vi, input logic [DW-1:0] vq);
    smp_valid[c] = 1'b1;
    smp_i[c*DW +: DW] = vi;
    smp_q[c*DW +: DW] = vq;
    step();
    smp_valid[c] = 1'b0;
    m_pend[c] = 1; m_i[c] = vi; m_q[c] = vq;
  endtask

  // predict service order: ascending from last served, masked ones skipped
  task automatic predict();
    bit found;
    do begin
      found = 0;
      for (int k = 1; k <= NCH && !found; k++) begin
        int j;
        j = (m_last + k) % NCH;
        if (m_pend[j] && chan_mask[j]) begin
          exp_q.push_back('{d: m_i[j], iq: 1'b1, ch: 2'(j)});
          exp_q.push_back('{d: m_q[j], iq: 1'b0, ch: 2'(j)});
          m_pend[j] = 0; m_last = j; found = 1;
        end
      end
    end while (found);
  endtask

  task automatic drain();
    int t;
    pp_ack = 1'b1;
    t = 0;
    while (exp_q.size() != 0 && t < 200) begin step(); t++; end
    step();
    pp_ack = 1'b0;
    step();
    chk(exp_q.size() == 0, "R2 drain complete", 32'(exp_q.size()), 0);
    chk(pp_req == 1'b0, "R2 req low when nothing eligible", 32'(pp_req), 0);
  endtask

  function automatic logic [3:0] model_ready();
    logic [3:0] r;
    for (int c = 0; c < NCH; c++) r[c] = !m_pend[c];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) m_pend[c] = 0;
    repeat (3) step();
    // R1 reset state
    chk(pp_data == 0 && pp_iq == 0 && pp_chan == 0 && pp_req == 0, "R1 bus at reset",
        32'({pp_data, pp_iq, pp_chan, pp_req}), 0);
    chk(ovf_flag == 0, "R1 ovf at reset", 32'(ovf_flag), 0);
    chk(smp_ready == 4'hF, "R1 ready at reset", 32'(smp_ready), 32'hF);
    rst_n = 1'b1;
    port_en = 1'b1; port_chmode = 1'b1; chan_mask = 4'hF;
    step();

    // R2/R3/R4 two channels, back-to-back beats
    load(0, 16'h1110, 16'h2220);
    load(2, 16'h1112, 16'h2222);
    chk(pp_req == 1'b1, "R2 req with pending", 32'(pp_req), 1);
    chk(smp_ready == model_ready(), "R10 ready tracks slots", 32'(smp_ready), 32'(model_ready()));
    predict();
    drain();

    // R6 wrap: last served 2; load 0,1,3 -> order 3,0,1
    load(1, 16'hA001, 16'hB001);
    load(3, 16'hA003, 16'hB003);
    load(0, 16'hA000, 16'hB000);
    predict();
    drain();

    // R5 stall between I and Q
    load(2, 16'h5552, 16'h6662);
    predict();
    pp_ack = 1'b1;
    step();
    pp_ack = 1'b0;
    repeat (3) step();
    chk(pp_iq == 1'b1 && pp_data == 16'h5552, "R5 I held while ack low",
        32'({pp_data, pp_iq}), 32'({16'h5552, 1'b1}));
    chk(pp_req == 1'b1, "R2 req held while Q owed", 32'(pp_req), 1);
    drain();

    // R7 overwrite
    load(2, 16'h0BAD, 16'h0BAD);
    load(2, 16'h600D, 16'h700D);
    chk(ovf_flag == 4'b0100, "R7 ovf set", 32'(ovf_flag), 32'h4);
    chk(smp_ready == 4'b1011, "R10 ready low when pending", 32'(smp_ready), 32'hB);
    predict();
    drain();
    chk(ovf_flag == 4'b0100, "R7 ovf sticky", 32'(ovf_flag), 32'h4);

    // R6 mask skip: mask channels 1 and 3 only
    chan_mask = 4'b1010;
    load(0, 16'hC000, 16'hD000);
    load(1, 16'hC001, 16'hD001);
    load(2, 16'hC002, 16'hD002);
    load(3, 16'hC003, 16'hD003);
    predict();
    drain();
    chk(smp_ready == 4'b1010, "R6 masked still pending", 32'(smp_ready), 32'hA);

    // R8 disable
    port_en = 1'b0;
    step();
    chk(pp_data == 0 && pp_iq == 0 && pp_chan == 0 && pp_req == 0, "R8 outputs zero",
        32'({pp_data, pp_iq, pp_chan, pp_req}), 0);
    for (int c = 0; c < NCH; c++) m_pend[c] = 0;
    m_last = NCH - 1;
    port_en = 1'b1; chan_mask = 4'hF;
    step();
    chk(pp_req == 1'b0, "R8 pending cleared", 32'(pp_req), 0);
    chk(smp_ready == 4'hF, "R8 slots empty", 32'(smp_ready), 32'hF);
    load(1, 16'hE001, 16'hF001);
    load(0, 16'hE000, 16'hF000);
    predict();
    drain();

    // R9 link mode
    port_chmode = 1'b0; link_byte = 8'hA5;
    step();
    chk(pp_data == 16'h00A5 && pp_req == 0 && pp_iq == 0, "R9 link byte lane",
        32'({pp_data, pp_req}), 32'({16'h00A5, 1'b0}));
    link_byte = 8'h3C;
    #1;
    chk(pp_data == 16'h003C, "R9 link follows input", 32'(pp_data), 32'h3C);
    port_chmode = 1'b1; m_last = NCH - 1;
    step();
    load(3, 16'h7773, 16'h8883);
    load(2, 16'h7772, 16'h8882);
    predict();
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule